// File: doc/BRIEF.md
# Multiprocessor-Format Serial Receiver with Station Address Filter

This block receives asynchronous serial frames on a line that several stations share. Each frame carries one extra flag bit after the data byte. When the flag is 1, the byte is an address naming one station. When it is 0, the byte is payload for whichever station was addressed last. The receiver compares every address byte with its own configured station number. It then passes payload to the host only while it is the addressed station. Payload meant for other stations is dropped without any flag being raised.

Bits are recovered by oversampling. An external enable, `os_tick`, pulses sixteen times per bit period. Each bit is sampled near its centre. A falling edge that does not stay low until mid-bit is discarded as noise. The host reads `rx_data` while `rx_valid` is high, and acknowledges with `rd_ack`. Framing and overrun problems are reported on sticky flags that `err_clr` clears. An optional control input also hands matching address bytes to the host, tagged by `rx_is_id`.

Top module: `mpr_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_is_id`, `frame_err` and `overrun_err` are 0. The receiver starts out unaddressed, so a payload frame that arrives before any address frame is not delivered.
- R2: A frame is one low start bit, eight data bits sent LSB first, one flag bit and one high stop bit. No parity bit is present or checked. `rx_data` bit i holds the i-th data bit received.
- R3: An address frame (flag 1) whose byte equals `station_id` makes the receiver addressed. Each later payload frame (flag 0) then loads `rx_data`, sets `rx_valid` and clears `rx_is_id`.
- R4: An address frame whose byte differs from `station_id` makes the receiver unaddressed. Later payload frames leave `rx_data`, `rx_valid` and `overrun_err` unchanged.
- R5: With `pass_id` = 0, a matching address frame is not delivered. With `pass_id` = 1, a matching address frame is delivered: `rx_data` holds the address, `rx_valid` = 1 and `rx_is_id` = 1. A non-matching address frame is never delivered.
- R6: A one-cycle pulse on `rd_ack` clears `rx_valid`.
- R7: If a frame that would be delivered completes while `rx_valid` is still set (and `rd_ack` is not high), `overrun_err` is set. `rx_data` keeps the older byte.
- R8: A frame whose stop bit samples low sets `frame_err`. That frame is not delivered and does not change the addressed state. The receiver waits for the line to return high before it looks for the next start bit.
- R9: A low pulse on the line that ends before the start bit's midpoint produces no frame. A normal frame that follows it is received correctly.
- R10: A one-cycle pulse on `err_clr` clears both `frame_err` and `overrun_err`.
- R11: The bit timing advances only on cycles where `os_tick` is high. With `os_tick` high one cycle in three, frames whose bit period is 48 clocks are received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial line, idle high |
| station_id | input | 8 | This station's address |
| pass_id | input | 1 | Also deliver matching address bytes to the host |
| rd_ack | input | 1 | Host has consumed `rx_data`; clears `rx_valid` |
| err_clr | input | 1 | Clears both error flags |
| rx_data | output | 8 | Last delivered byte |
| rx_valid | output | 1 | `rx_data` holds an unread byte |
| rx_is_id | output | 1 | The delivered byte was an address |
| frame_err | output | 1 | Sticky: stop bit sampled low |
| overrun_err | output | 1 | Sticky: a delivery was lost because `rx_valid` was still set |

## Verification
Every frame result appears in the outputs once the stop bit's mid-sample has been taken and registered. That is about ten oversample ticks plus three clocks after the stop bit begins: two synchronizer stages and one output register. For delivered frames, the bench reads `rx_valid` four ticks into the stop bit, where it must still be low. All outputs are then checked only after one full idle bit time has followed the stop bit. `rd_ack` and `err_clr` act on the next clock edge, so their effects are checked one clock after the pulse.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  typedef enum logic [2:0] {
    SM_IDLE  = 3'd0,
    SM_START = 3'd1,
    SM_BITS  = 3'd2,
    SM_STOP  = 3'd3,
    SM_BREAK = 3'd4
  } samp_state_e;

  typedef enum logic {
    FLT_IGNORE = 1'b0,
    FLT_ACCEPT = 1'b1
  } filt_state_e;
endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] ff_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q[g] <= 1'b1;
        else        ff_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q[g] <= 1'b1;
        else        ff_q[g] <= ff_q[g-1];
      end
    end
  end

  assign dout = ff_q[STAGES-1];
endmodule

// File: rtl/mpr_sampler.sv
module mpr_sampler
  import mpr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_s,
  output logic              done,
  output logic [DATA_W-1:0] frm_data,
  output logic              frm_mpb,
  output logic              frm_stop_ok
);
  localparam int NBITS = DATA_W + 1;
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(NBITS);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  samp_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [NBITS-1:0] shf_q, shf_d;
  logic             done_q, done_d;
  logic             stop_q, stop_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    shf_d  = shf_q;
    done_d = 1'b0;
    stop_d = stop_q;
    unique case (st_q)
      SM_IDLE: begin
        if (tick && !rx_s) begin
          st_d  = SM_START;
          cnt_d = '0;
        end
      end
      SM_START: begin
        if (tick) begin
          if (cnt_q == MID) begin
            cnt_d = '0;
            bit_d = '0;
            st_d  = rx_s ? SM_IDLE : SM_BITS;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      SM_BITS: begin
        if (tick) begin
          if (cnt_q == LAST) begin
            cnt_d = '0;
            shf_d = {rx_s, shf_q[NBITS-1:1]};
            if (bit_q == BIT_W'(NBITS - 1)) st_d = SM_STOP;
            else                            bit_d = bit_q + BIT_W'(1);
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      SM_STOP: begin
        if (tick) begin
          if (cnt_q == LAST) begin
            stop_d = rx_s;
            done_d = 1'b1;
            st_d   = rx_s ? SM_IDLE : SM_BREAK;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      SM_BREAK: begin
        if (rx_s) st_d = SM_IDLE;
      end
      default: st_d = SM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SM_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      shf_q  <= '0;
      done_q <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      shf_q  <= shf_d;
      done_q <= done_d;
      stop_q <= stop_d;
    end
  end

  assign done        = done_q;
  assign frm_data    = shf_q[DATA_W-1:0];
  assign frm_mpb     = shf_q[NBITS-1];
  assign frm_stop_ok = stop_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R2
  AST_BREAK_WAITS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SM_BREAK && !rx_s) |=> (st_q == SM_BREAK)); // R8
  AST_GLITCH_NO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SM_START && tick && cnt_q == MID && rx_s) |=> (st_q == SM_IDLE)); // R9
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && st_q != SM_BREAK) |=> ($stable(cnt_q) && $stable(st_q))); // R11
endmodule

// File: rtl/mpr_filter.sv
module mpr_filter
  import mpr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_mpb,
  input  logic              frm_stop_ok,
  input  logic [DATA_W-1:0] station_id,
  input  logic              pass_id,
  input  logic              rd_ack,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_is_id,
  output logic              frame_err,
  output logic              overrun_err
);
  filt_state_e       fst_q, fst_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              valid_q, valid_d;
  logic              isid_q, isid_d;
  logic              ferr_q, ferr_d;
  logic              ovr_q, ovr_d;
  logic              good, id_hit, deliver, blocked;

  always_comb begin
    good    = done && frm_stop_ok;
    id_hit  = (frm_data == station_id);
    deliver = good && (frm_mpb ? (id_hit && pass_id) : (fst_q == FLT_ACCEPT));
    blocked = valid_q && !rd_ack;

    fst_d   = fst_q;
    data_d  = data_q;
    valid_d = valid_q;
    isid_d  = isid_q;
    ferr_d  = ferr_q;
    ovr_d   = ovr_q;

    if (good && frm_mpb) fst_d = id_hit ? FLT_ACCEPT : FLT_IGNORE;

    if (rd_ack) valid_d = 1'b0;
    if (deliver) begin
      if (blocked) begin
        ovr_d = 1'b1;
      end else begin
        data_d  = frm_data;
        isid_d  = frm_mpb;
        valid_d = 1'b1;
      end
    end

    if (err_clr) begin
      ferr_d = 1'b0;
      if (!(deliver && blocked)) ovr_d = 1'b0;
    end
    if (done && !frm_stop_ok) ferr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst_q   <= FLT_IGNORE;
      data_q  <= '0;
      valid_q <= 1'b0;
      isid_q  <= 1'b0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      fst_q   <= fst_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      isid_q  <= isid_d;
      ferr_q  <= ferr_d;
      ovr_q   <= ovr_d;
    end
  end

  assign rx_data     = data_q;
  assign rx_valid    = valid_q;
  assign rx_is_id    = isid_q;
  assign frame_err   = ferr_q;
  assign overrun_err = ovr_q;

  AST_VALID_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(done)); // R3
  AST_IGNORED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !frm_mpb && fst_q == FLT_IGNORE && !err_clr)
      |=> ($stable(data_q) && $stable(ovr_q))); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !done) |=> !valid_q); // R6
  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $stable(data_q)); // R7
  AST_FERR_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !frm_stop_ok) |=> ($stable(data_q) && $stable(fst_q) && ferr_q)); // R8
endmodule

// File: rtl/mpr_rx.sv
module mpr_rx #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic [DATA_W-1:0] station_id,
  input  logic              pass_id,
  input  logic              rd_ack,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_is_id,
  output logic              frame_err,
  output logic              overrun_err
);
  logic              rx_s;
  logic              done;
  logic [DATA_W-1:0] frm_data;
  logic              frm_mpb;
  logic              frm_stop_ok;

  mpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (rx_s)
  );

  mpr_sampler #(.DATA_W(DATA_W), .OSR(OSR)) u_samp (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (os_tick),
    .rx_s       (rx_s),
    .done       (done),
    .frm_data   (frm_data),
    .frm_mpb    (frm_mpb),
    .frm_stop_ok(frm_stop_ok)
  );

  mpr_filter #(.DATA_W(DATA_W)) u_filt (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .frm_data   (frm_data),
    .frm_mpb    (frm_mpb),
    .frm_stop_ok(frm_stop_ok),
    .station_id (station_id),
    .pass_id    (pass_id),
    .rd_ack     (rd_ack),
    .err_clr    (err_clr),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .rx_is_id   (rx_is_id),
    .frame_err  (frame_err),
    .overrun_err(overrun_err)
  );
endmodule

// File: tb/tb_mpr_rx.sv
`timescale 1ns/1ps
module tb_mpr_rx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       os_tick;
  logic       rxd;
  logic [7:0] station_id;
  logic       pass_id;
  logic       rd_ack;
  logic       err_clr;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_is_id;
  logic       frame_err;
  logic       overrun_err;

  int n_chk = 0;
  int n_bad = 0;
  int tick_div = 1;
  int tick_cnt = 0;
  logic early_valid;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mpr_rx dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .station_id(station_id), .pass_id(pass_id), .rd_ack(rd_ack),
    .err_clr(err_clr), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_is_id(rx_is_id), .frame_err(frame_err), .overrun_err(overrun_err)
  );

  always @(negedge clk) begin
    if (tick_cnt >= tick_div - 1) begin
      os_tick  <= 1'b1;
      tick_cnt <= 0;
    end else begin
      os_tick  <= 1'b0;
      tick_cnt <= tick_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic mpb, input logic stp);
    int bl;
    bl = 16 * tick_div;
    rxd = 1'b0;
    repeat (bl) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (bl) @(negedge clk);
    end
    rxd = mpb;
    repeat (bl) @(negedge clk);
    rxd = stp;
    repeat (4 * tick_div) @(negedge clk);
    early_valid = rx_valid;
    repeat (bl - 4 * tick_div) @(negedge clk);
    rxd = 1'b1;
    repeat (bl) @(negedge clk);
  endtask

  task automatic pulse_ack();
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 valid after reset", rx_valid, 0);
    check("R1 is_id after reset", rx_is_id, 0);
    check("R1 frame_err after reset", frame_err, 0);
    check("R1 overrun after reset", overrun_err, 0);
    send_frame(8'h55, 1'b0, 1'b1);
    check("R1 unaddressed payload dropped", rx_valid, 0);
  endtask

  task automatic t_match();
    send_frame(8'h5A, 1'b1, 1'b1);
    check("R5 matching id silent when pass_id=0", rx_valid, 0);
    send_frame(8'hC3, 1'b0, 1'b1);
    check("R3 valid not early in stop bit", early_valid, 0);
    check("R3 valid after payload", rx_valid, 1);
    check("R3 data", rx_data, 8'hC3);
    check("R3 is_id clear", rx_is_id, 0);
    pulse_ack();
    check("R6 ack clears valid", rx_valid, 0);
    send_frame(8'h81, 1'b0, 1'b1);
    check("R2 lsb-first pattern", rx_data, 8'h81);
    send_frame(8'h00, 1'b0, 1'b1);
    check("R7 overrun on unread", overrun_err, 1);
    check("R7 older data kept", rx_data, 8'h81);
    pulse_clr();
    check("R10 clr overrun", overrun_err, 0);
    pulse_ack();
  endtask

  task automatic t_mismatch();
    send_frame(8'h11, 1'b1, 1'b1);
    check("R4 foreign id not delivered", rx_valid, 0);
    send_frame(8'h77, 1'b0, 1'b1);
    check("R4 foreign payload no valid", rx_valid, 0);
    check("R4 foreign payload no overrun", overrun_err, 0);
    check("R4 data unchanged", rx_data, 8'h81);
  endtask

  task automatic t_pass_id();
    pass_id = 1'b1;
    send_frame(8'h5A, 1'b1, 1'b1);
    check("R5 pass id valid", rx_valid, 1);
    check("R5 pass id data", rx_data, 8'h5A);
    check("R5 pass id tag", rx_is_id, 1);
    pulse_ack();
    send_frame(8'h22, 1'b1, 1'b1);
    check("R5 foreign id never delivered", rx_valid, 0);
    check("R5 foreign id data kept", rx_data, 8'h5A);
    pass_id = 1'b0;
  endtask

  task automatic t_framing();
    send_frame(8'h5A, 1'b1, 1'b1);
    send_frame(8'h33, 1'b0, 1'b0);
    check("R8 frame_err set", frame_err, 1);
    check("R8 bad frame not delivered", rx_valid, 0);
    send_frame(8'h44, 1'b0, 1'b1);
    check("R8 still addressed after bad frame", rx_valid, 1);
    check("R8 next frame data", rx_data, 8'h44);
    check("R8 frame_err sticky", frame_err, 1);
    pulse_clr();
    check("R10 clr frame_err", frame_err, 0);
    pulse_ack();
  endtask

  task automatic t_glitch();
    rxd = 1'b0;
    repeat (5) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    check("R9 glitch gives no frame", rx_valid, 0);
    send_frame(8'h66, 1'b0, 1'b1);
    check("R9 frame after glitch", rx_data, 8'h66);
    pulse_ack();
  endtask

  task automatic t_slow_tick();
    tick_div = 3;
    repeat (6) @(negedge clk);
    send_frame(8'h99, 1'b0, 1'b1);
    check("R11 valid not early at slow tick", early_valid, 0);
    check("R11 valid at slow tick", rx_valid, 1);
    check("R11 data at slow tick", rx_data, 8'h99);
    pulse_ack();
    tick_div = 1;
  endtask

  initial begin
    rst_n = 1'b0;
    rxd = 1'b1;
    station_id = 8'h5A;
    pass_id = 1'b0;
    rd_ack = 1'b0;
    err_clr = 1'b0;
    early_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_match();
    t_mismatch();
    t_pass_id();
    t_framing();
    t_glitch();
    t_slow_tick();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule